// File: doc/BRIEF.md
# MESIF Line Coherence State Controller

This block holds the coherence state of a small array of cache lines for one cache that sits on a snooping bus shared with other caches. Each line can be in one of five states: Invalid, Shared, Exclusive, Modified or Forward. Requests come from two sides. The local processor side issues read, write and evict operations. The bus side snoops other caches' reads and ownership requests. For each request the block updates the line state. It reports what the cache must do on the bus: issue a read or an ownership request, supply data cache-to-cache, or write a dirty line back to memory.

Only a line in Forward, Exclusive or Modified answers another cache's read with data. A Shared line stays silent, and if no cache holds Forward then memory answers the read. The Forward role passes to the newest reader. A local read miss that another cache fills installs Forward. The cache that supplied the data drops to Shared. A line enters Shared only by answering a remote read.

The parameter `NUM_LINES` sets the number of lines and must be a power of two. Every response is registered and appears one cycle after the request. A combinational query port reads back the state of any line.

Top module: `mesif_line_ctrl`

## Requirements
- R1: After reset every line reads back Invalid and all response outputs are low. The state codes on `q_state` are Invalid=0, Shared=1, Exclusive=2, Modified=3 and Forward=4, and no other code ever appears.
- R2: Each response (`snp_supply`, `snp_wb`, `bus_rd`, `bus_own`, `evict_wb`) is a one-cycle pulse on the clock edge that samples the request. It is low in any cycle whose previous cycle had no matching request.
- R3: A local read (`lcl_op`=0) to an Invalid line pulses `bus_rd`. The line becomes Forward if `lcl_peer_fill` is high and Exclusive otherwise. A read to a valid line changes nothing and pulses nothing.
- R4: A local read miss never installs Shared.
- R5: A snooped read (`snp_op`=0) to a Forward line pulses `snp_supply` and moves the line to Shared.
- R6: A snooped read to a Shared or Invalid line leaves the state unchanged and keeps `snp_supply` low, so memory answers.
- R7: A snooped read to an Exclusive or Modified line pulses `snp_supply` and moves the line to Shared. A Modified line also pulses `snp_wb`.
- R8: A local write (`lcl_op`=1) moves the line to Modified. From Shared, Forward or Invalid it pulses `bus_own`. From Exclusive or Modified it stays silent.
- R9: A snooped ownership request (`snp_op`=1) moves any line to Invalid. Only a Modified line pulses `snp_supply` and `snp_wb`.
- R10: A local evict (`lcl_op`=2) moves the line to Invalid without notice. Only a Modified line pulses `evict_wb`. `lcl_op`=3 does nothing.
- R11: When a snoop and a local request name the same line in one cycle, the snoop is applied first and the local request acts on the result. Requests to different lines are independent.
- R12: `snp_wb` is never high without `snp_supply`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_valid | input | 1 | Local request present |
| lcl_op | input | 2 | Local operation: 0 read, 1 write, 2 evict, 3 none |
| lcl_idx | input | log2(NUM_LINES) | Line addressed by the local request |
| lcl_peer_fill | input | 1 | A read miss in this cycle is filled by another cache |
| snp_valid | input | 1 | Snooped request present |
| snp_op | input | 1 | Snoop operation: 0 read, 1 ownership request |
| snp_idx | input | log2(NUM_LINES) | Line addressed by the snoop |
| q_idx | input | log2(NUM_LINES) | Line to read back |
| q_state | output | 3 | State code of line `q_idx` |
| snp_supply | output | 1 | Supply data cache-to-cache for the snoop |
| snp_wb | output | 1 | Write dirty data back because of a snoop |
| bus_rd | output | 1 | Issue a bus read for a local miss |
| bus_own | output | 1 | Issue an invalidating ownership request |
| evict_wb | output | 1 | Write back a dirty line that is being evicted |

## Verification
The assertions check on every cycle that:
- only the five state codes occur (R1);
- a read miss always issues a bus read and never installs Shared (R3, R4);
- an ownership snoop always leaves the line Invalid when no local request hits the same line (R9);
- snoop writeback never occurs without a supply (R12);
- a supply never occurs without a snoop in the cycle before (R2).

Only the bench's scenarios can show the full transition table. This covers the handover of the Forward role, the silence of Shared lines, the difference between a memory fill and a peer fill, and the ordering when a snoop and a local request collide on the same line.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_M = 3'd3,
        ST_F = 3'd4
    } mesif_st_e;

    typedef enum logic [1:0] {
        LOP_READ  = 2'd0,
        LOP_WRITE = 2'd1,
        LOP_EVICT = 2'd2,
        LOP_NONE  = 2'd3
    } lcl_op_e;

endpackage

// File: rtl/mesif_snoop_xfer.sv
module mesif_snoop_xfer
    import mesif_pkg::*;
(
    input  logic      active,
    input  logic      op_own,
    input  mesif_st_e cur,
    output mesif_st_e nxt,
    output logic      supply,
    output logic      wb
);

    always_comb begin
        nxt    = cur;
        supply = 1'b0;
        wb     = 1'b0;
        if (active) begin
            if (op_own) begin
                // ownership request: every copy dies, dirty data is handed over
                nxt = ST_I;
                if (cur == ST_M) begin
                    supply = 1'b1;
                    wb     = 1'b1;
                end
            end else begin
                case (cur)
                    ST_M: begin
                        nxt    = ST_S;
                        supply = 1'b1;
                        wb     = 1'b1;
                    end
                    ST_E, ST_F: begin
                        nxt    = ST_S;
                        supply = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mesif_local_xfer.sv
module mesif_local_xfer
    import mesif_pkg::*;
(
    input  logic       active,
    input  logic [1:0] op,
    input  logic       peer_fill,
    input  mesif_st_e  cur,
    output mesif_st_e  nxt,
    output logic       rd_req,
    output logic       own_req,
    output logic       wb
);

    always_comb begin
        nxt     = cur;
        rd_req  = 1'b0;
        own_req = 1'b0;
        wb      = 1'b0;
        if (active) begin
            case (lcl_op_e'(op))
                LOP_READ: begin
                    if (cur == ST_I) begin
                        rd_req = 1'b1;
                        nxt    = peer_fill ? ST_F : ST_E;
                    end
                end
                LOP_WRITE: begin
                    if (cur == ST_I || cur == ST_S || cur == ST_F) begin
                        own_req = 1'b1;
                    end
                    nxt = ST_M;
                end
                LOP_EVICT: begin
                    wb  = (cur == ST_M);
                    nxt = ST_I;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
    import mesif_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcl_valid,
    input  logic [1:0]       lcl_op,
    input  logic [IDX_W-1:0] lcl_idx,
    input  logic             lcl_peer_fill,
    input  logic             snp_valid,
    input  logic             snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [IDX_W-1:0] q_idx,
    output logic [2:0]       q_state,
    output logic             snp_supply,
    output logic             snp_wb,
    output logic             bus_rd,
    output logic             bus_own,
    output logic             evict_wb
);

    typedef struct packed {
        mesif_st_e [NUM_LINES-1:0] line;
        logic                      supply;
        logic                      swb;
        logic                      rd;
        logic                      own;
        logic                      ewb;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    mesif_st_e snp_cur, snp_nxt, lcl_cur, lcl_nxt;
    logic      s_supply, s_wb, l_rd, l_own, l_wb;
    logic      same_line;

    // flattened view for the bound checker
    logic [NUM_LINES*3-1:0] line_flat;
    assign line_flat = ctl_q.line;

    assign snp_cur   = ctl_q.line[snp_idx];
    assign same_line = snp_valid && (snp_idx == lcl_idx);
    // local request sees the line after the snoop has acted on it
    assign lcl_cur   = same_line ? snp_nxt : ctl_q.line[lcl_idx];

    mesif_snoop_xfer u_snp (
        .active (snp_valid),
        .op_own (snp_op),
        .cur    (snp_cur),
        .nxt    (snp_nxt),
        .supply (s_supply),
        .wb     (s_wb)
    );

    mesif_local_xfer u_lcl (
        .active    (lcl_valid),
        .op        (lcl_op),
        .peer_fill (lcl_peer_fill),
        .cur       (lcl_cur),
        .nxt       (lcl_nxt),
        .rd_req    (l_rd),
        .own_req   (l_own),
        .wb        (l_wb)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.supply = s_supply;
        ctl_d.swb    = s_wb;
        ctl_d.rd     = l_rd;
        ctl_d.own    = l_own;
        ctl_d.ewb    = l_wb;
        if (snp_valid) ctl_d.line[snp_idx] = snp_nxt;
        if (lcl_valid) ctl_d.line[lcl_idx] = lcl_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign q_state    = ctl_q.line[q_idx];
    assign snp_supply = ctl_q.supply;
    assign snp_wb     = ctl_q.swb;
    assign bus_rd     = ctl_q.rd;
    assign bus_own    = ctl_q.own;
    assign evict_wb   = ctl_q.ewb;

endmodule

// File: rtl/mesif_line_chk.sv
module mesif_line_chk #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lcl_valid,
    input logic [1:0]             lcl_op,
    input logic [IDX_W-1:0]       lcl_idx,
    input logic                   snp_valid,
    input logic                   snp_op,
    input logic [IDX_W-1:0]       snp_idx,
    input logic                   snp_supply,
    input logic                   snp_wb,
    input logic                   bus_rd,
    input logic [NUM_LINES*3-1:0] line_flat
);

    logic [2:0] lcl_line_st;
    assign lcl_line_st = line_flat[lcl_idx*3 +: 3];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // R1
        legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_flat[g*3 +: 3] <= 3'd4);
    end

    // R12
    wb_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wb |-> snp_supply);

    // R2
    supply_after_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> $past(snp_valid));

    // R3
    miss_issues_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_op == 2'd0 && lcl_line_st == 3'd0 && !snp_valid) |=> bus_rd);

    // R4
    fill_not_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_op == 2'd0 && lcl_line_st == 3'd0 && !snp_valid)
        |=> line_flat[$past(lcl_idx)*3 +: 3] != 3'd1);

    // R9
    own_snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op && !(lcl_valid && lcl_idx == snp_idx))
        |=> line_flat[$past(snp_idx)*3 +: 3] == 3'd0);

endmodule

bind mesif_line_ctrl mesif_line_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcl_valid  (lcl_valid),
    .lcl_op     (lcl_op),
    .lcl_idx    (lcl_idx),
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .snp_idx    (snp_idx),
    .snp_supply (snp_supply),
    .snp_wb     (snp_wb),
    .bus_rd     (bus_rd),
    .line_flat  (line_flat)
);

// File: tb/mesif_line_ctrl_tb.sv
module mesif_line_ctrl_tb;

    localparam int N = 8;
    localparam int IW = 3;
    localparam logic [2:0] SI = 3'd0, SS = 3'd1, SE = 3'd2, SM = 3'd3, SF = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lcl_valid = 1'b0, lcl_peer_fill = 1'b0, snp_valid = 1'b0, snp_op = 1'b0;
    logic [1:0] lcl_op = 2'd3;
    logic [IW-1:0] lcl_idx = '0, snp_idx = '0, q_idx = '0;
    logic [2:0] q_state;
    logic snp_supply, snp_wb, bus_rd, bus_own, evict_wb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mesif_line_ctrl #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_idx(lcl_idx), .lcl_peer_fill(lcl_peer_fill),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
        .q_idx(q_idx), .q_state(q_state),
        .snp_supply(snp_supply), .snp_wb(snp_wb), .bus_rd(bus_rd),
        .bus_own(bus_own), .evict_wb(evict_wb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_st(input string tag, input int idx, input logic [2:0] exp);
        q_idx = IW'(idx);
        #1;
        chk(tag, q_state, exp);
    endtask

    task automatic apply(input logic lv, input logic [1:0] lop, input int li, input logic pf,
                         input logic sv, input logic sop, input int si);
        @(negedge clk);
        lcl_valid = lv; lcl_op = lop; lcl_idx = IW'(li); lcl_peer_fill = pf;
        snp_valid = sv; snp_op = sop; snp_idx = IW'(si);
        @(posedge clk);
        #1;
        lcl_valid = 1'b0; snp_valid = 1'b0; lcl_op = 2'd3;
    endtask

    task automatic lcl(input logic [1:0] op, input int idx, input logic pf);
        apply(1'b1, op, idx, pf, 1'b0, 1'b0, 0);
    endtask

    task automatic snp(input logic op, input int idx);
        apply(1'b0, 2'd3, 0, 1'b0, 1'b1, op, idx);
    endtask

    task automatic t_reset;
        for (int i = 0; i < N; i++) chk_st("R1 reset state", i, SI);
        chk("R1 reset supply", snp_supply, 0);
        chk("R1 reset outputs", {bus_rd, bus_own, evict_wb, snp_wb}, 0);
    endtask

    task automatic t_read_fill;
        lcl(2'd0, 1, 1'b0);
        chk("R3 miss bus_rd", bus_rd, 1);
        chk_st("R3 memory fill Exclusive", 1, SE);
        lcl(2'd0, 2, 1'b1);
        chk("R3 peer miss bus_rd", bus_rd, 1);
        chk_st("R4 peer fill Forward not Shared", 2, SF);
        lcl(2'd0, 2, 1'b1);
        chk("R3 hit no bus_rd", bus_rd, 0);
        chk_st("R3 hit unchanged", 2, SF);
        lcl(2'd3, 0, 1'b0);
        chk_st("R10 op3 no effect", 0, SI);
        @(posedge clk); #1;
        chk("R2 pulse ends", bus_rd, 0);
    endtask

    task automatic t_snoop_read;
        snp(1'b0, 2);
        chk("R5 forward supplies", snp_supply, 1);
        chk("R5 forward no wb", snp_wb, 0);
        chk_st("R5 forward to Shared", 2, SS);
        snp(1'b0, 2);
        chk("R6 shared silent", snp_supply, 0);
        chk_st("R6 shared unchanged", 2, SS);
        snp(1'b0, 0);
        chk("R6 invalid silent", snp_supply, 0);
        chk_st("R6 invalid unchanged", 0, SI);
        snp(1'b0, 1);
        chk("R7 exclusive supplies", snp_supply, 1);
        chk("R7 exclusive no wb", snp_wb, 0);
        chk_st("R7 exclusive to Shared", 1, SS);
    endtask

    task automatic t_write;
        lcl(2'd0, 3, 1'b0);
        lcl(2'd1, 3, 1'b0);
        chk("R8 exclusive write silent", bus_own, 0);
        chk_st("R8 exclusive to Modified", 3, SM);
        lcl(2'd1, 2, 1'b0);
        chk("R8 shared write owns", bus_own, 1);
        chk_st("R8 shared to Modified", 2, SM);
        lcl(2'd1, 4, 1'b0);
        chk("R8 invalid write owns", bus_own, 1);
        chk_st("R8 invalid to Modified", 4, SM);
        lcl(2'd1, 4, 1'b0);
        chk("R8 modified write silent", bus_own, 0);
        snp(1'b0, 4);
        chk("R7 modified supplies", snp_supply, 1);
        chk("R7 modified wb", snp_wb, 1);
        chk_st("R7 modified to Shared", 4, SS);
    endtask

    task automatic t_own;
        snp(1'b1, 3);
        chk("R9 modified own supplies", snp_supply, 1);
        chk("R9 modified own wb", snp_wb, 1);
        chk_st("R9 modified to Invalid", 3, SI);
        lcl(2'd0, 5, 1'b1);
        snp(1'b1, 5);
        chk("R9 forward own silent", snp_supply, 0);
        chk_st("R9 forward to Invalid", 5, SI);
    endtask

    task automatic t_evict;
        lcl(2'd2, 2, 1'b0);
        chk("R10 modified evict wb", evict_wb, 1);
        chk_st("R10 modified evict Invalid", 2, SI);
        lcl(2'd2, 1, 1'b0);
        chk("R10 shared evict silent", evict_wb, 0);
        chk_st("R10 shared evict Invalid", 1, SI);
    endtask

    task automatic t_collide;
        lcl(2'd1, 6, 1'b0);
        apply(1'b1, 2'd0, 6, 1'b0, 1'b1, 1'b1, 6);
        chk("R11 same line snoop wb", snp_wb, 1);
        chk("R11 same line then miss", bus_rd, 1);
        chk_st("R11 same line refilled Exclusive", 6, SE);
        apply(1'b1, 2'd0, 7, 1'b1, 1'b1, 1'b0, 4);
        chk("R11 split lines silent snoop", snp_supply, 0);
        chk_st("R11 split local Forward", 7, SF);
        chk_st("R11 split snoop Shared", 4, SS);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_read_fill;
        t_snoop_read;
        t_write;
        t_own;
        t_evict;
        t_collide;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule